// File: doc/BRIEF.md
# Table-Driven DAC Waveform Sequencer

This block masters the byte-wide parallel write bus of a 12-bit voltage-output DAC and plays a periodic waveform held in a small internal table. Once reset is released, it sends a single configuration byte. From then on a free-running divider produces a sample tick. On every tick the block takes the next table entry and writes its upper byte and then its lower byte to the DAC's two holding addresses. It then pulses the active-low load strobe, so the two bytes reach the converter output at the same moment.

A plain byte write port fills the table and can be used at any time. The block latches each sample when its tick is accepted, so a table write during a transfer cannot disturb the bus. Every bus phase lasts a parameterized number of system clocks, which lets the setup, pulse-width and hold minimums of the DAC be met at any clock rate. A tick that comes while a transfer is still running is discarded and recorded in a sticky overrun flag.

Top module: `dac_wave_seq`

## Requirements
- R1: While reset is asserted, chip select, write enable and load all sit high (inactive) and `overrun_o` is 0. Reset also clears every table byte to 0.
- R2: The first bus write after reset goes to address 3 with data 0x11, and it comes before any load pulse.
- R3: For each sample the block makes exactly two writes, address 1 first and then address 0. Only after both does the load strobe fall.
- R4: Table byte 2k is the upper byte of sample k and byte 2k+1 is its lower byte. The write to address 1 carries only bits 3:0 of the upper byte, with bits 7:4 driven to 0. The DAC word loaded is therefore {upper[3:0], lower}.
- R5: Samples are played in index order 0, 1, … SAMPLES-1, and the sequence then wraps back to 0. The byte pointer steps by 2 and wraps at the table size.
- R6: Write enable is low only while chip select is low. Address and data do not change while write enable is low or on the cycle where it rises.
- R7: The load strobe is low only while chip select and write enable are both high. Each load pulse lasts exactly PHASE_CYC clocks.
- R8: An accepted tick occurs every TICK_DIV clocks, so consecutive load pulses fall exactly TICK_DIV clocks apart when no tick is dropped.
- R9: A tick that arrives during a transfer is dropped without advancing the pointer, and `overrun_o` goes to 1 and stays there until reset. It stays 0 when TICK_DIV leaves room for a whole transfer.
- R10: A table write sets the addressed byte, and the new value appears in the next sample read from that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table byte write enable |
| tbl_addr_i | input | $clog2(2*SAMPLES) | Table byte address (even = upper byte) |
| tbl_data_i | input | 8 | Table byte write data |
| dac_cs_no | output | 1 | DAC chip select, active low |
| dac_we_no | output | 1 | DAC write strobe, active low, data taken on rising edge |
| dac_addr_o | output | 2 | DAC register address (0 lower, 1 upper, 3 configuration) |
| dac_data_o | output | 8 | DAC data byte |
| dac_ldac_no | output | 1 | DAC load strobe, active low |
| overrun_o | output | 1 | Sticky flag: a sample tick was dropped |

## Verification
Two copies of the block are built side by side. The first uses TICK_DIV=50 and PHASE_CYC=2, so a transfer of 16 clocks fits easily inside the tick period. This copy covers ordering, data masking, wrap past entry 31 and the exact spacing of load pulses without any dropped tick. The second uses TICK_DIV=12 with the same phase length, so every other tick lands inside a transfer. That setting makes the overrun path, the sticky flag and a load spacing of twice the divider reachable within a few hundred clocks.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [2:0] {
    ST_CFG, ST_IDLE, ST_WR_HI, ST_WR_LO, ST_LD_GAP, ST_LD_LOW
  } seq_state_e;

  typedef enum logic [1:0] {PH_SETUP, PH_STROBE, PH_HOLD} wr_phase_e;

  localparam logic [1:0] DAC_ADDR_LO  = 2'd0;
  localparam logic [1:0] DAC_ADDR_HI  = 2'd1;
  localparam logic [1:0] DAC_ADDR_CFG = 2'd3;
endpackage

// File: rtl/dac_tick_div.sv
module dac_tick_div #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_wave_table.sv
module dac_wave_table #(
  parameter int unsigned SAMPLES = 32,
  parameter int unsigned HI_KEEP = 4,
  localparam int unsigned BYTES  = SAMPLES * 2,
  localparam int unsigned AW     = $clog2(BYTES),
  localparam int unsigned IW     = AW - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [IW-1:0]      ridx_i,
  output logic [HI_KEEP-1:0] rhi_o,
  output logic [7:0]         rlo_o
);
  logic [7:0] mem_q [BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(BYTES); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // even byte = upper, odd byte = lower
  assign rhi_o = mem_q[{ridx_i, 1'b0}][HI_KEEP-1:0];
  assign rlo_o = mem_q[{ridx_i, 1'b1}];
endmodule

// File: rtl/dac_bus_seq.sv
module dac_bus_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned SAMPLES   = 32,
  parameter int unsigned PHASE_CYC = 2,
  parameter int unsigned HI_KEEP   = 4,
  parameter logic [7:0]  CFG_WORD  = 8'h11,
  localparam int unsigned PW  = $clog2(SAMPLES * 2),
  localparam int unsigned CCW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [HI_KEEP-1:0] rhi_i,
  input  logic [7:0]         rlo_i,
  output logic [PW-2:0]      ridx_o,
  output logic               cs_no,
  output logic               we_no,
  output logic [1:0]         addr_o,
  output logic [7:0]         data_o,
  output logic               ldac_no,
  output logic               overrun_o
);
  seq_state_e        state_q, state_d;
  wr_phase_e         ph_q, ph_d;
  logic [CCW-1:0]    cyc_q, cyc_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic [HI_KEEP-1:0] smp_hi_q;
  logic [7:0]        smp_lo_q;

  logic       phase_end, is_wr;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;

  assign phase_end = (cyc_q == CCW'(PHASE_CYC - 1));
  assign is_wr     = (state_q == ST_CFG) || (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
  assign ridx_o    = ptr_q[PW-1:1];

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    cyc_d   = cyc_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      ST_IDLE: if (tick_i) begin
        state_d = ST_WR_HI;
        ph_d    = PH_SETUP;
        cyc_d   = '0;
      end
      ST_CFG, ST_WR_HI, ST_WR_LO: begin
        if (phase_end) begin
          cyc_d = '0;
          if (ph_q == PH_HOLD) begin
            ph_d = PH_SETUP;
            unique case (state_q)
              ST_CFG:   state_d = ST_IDLE;
              ST_WR_HI: state_d = ST_WR_LO;
              default: begin
                state_d = ST_LD_GAP;
                ptr_d   = ptr_q + PW'(2);
              end
            endcase
          end else begin
            ph_d = wr_phase_e'(ph_q + 2'd1);
          end
        end else begin
          cyc_d = cyc_q + CCW'(1);
        end
      end
      ST_LD_GAP: begin
        cyc_d = phase_end ? '0 : cyc_q + CCW'(1);
        if (phase_end) state_d = ST_LD_LOW;
      end
      ST_LD_LOW: begin
        cyc_d = phase_end ? '0 : cyc_q + CCW'(1);
        if (phase_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_CFG:   begin wr_addr = DAC_ADDR_CFG; wr_data = CFG_WORD; end
      ST_WR_HI: begin wr_addr = DAC_ADDR_HI;  wr_data = {{(8-HI_KEEP){1'b0}}, smp_hi_q}; end
      ST_WR_LO: begin wr_addr = DAC_ADDR_LO;  wr_data = smp_lo_q; end
      default:  begin wr_addr = '0;           wr_data = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CFG;
      ph_q      <= PH_SETUP;
      cyc_q     <= '0;
      ptr_q     <= '0;
      smp_hi_q  <= '0;
      smp_lo_q  <= '0;
      overrun_o <= 1'b0;
      cs_no     <= 1'b1;
      we_no     <= 1'b1;
      addr_o    <= '0;
      data_o    <= '0;
      ldac_no   <= 1'b1;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      cyc_q   <= cyc_d;
      ptr_q   <= ptr_d;
      // sample frozen at acceptance so table writes cannot disturb the bus
      if (state_q == ST_IDLE && tick_i) begin
        smp_hi_q <= rhi_i;
        smp_lo_q <= rlo_i;
      end
      if (tick_i && state_q != ST_IDLE) overrun_o <= 1'b1;
      // registered pins: glitch-free, uniform one-cycle lag
      cs_no   <= !is_wr;
      we_no   <= !(is_wr && ph_q == PH_STROBE);
      addr_o  <= wr_addr;
      data_o  <= wr_data;
      ldac_no <= (state_q != ST_LD_LOW);
    end
  end
endmodule

// File: rtl/dac_wave_seq.sv
module dac_wave_seq #(
  parameter int unsigned SAMPLES   = 32,
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned PHASE_CYC = 2,
  parameter logic [7:0]  CFG_WORD  = 8'h11,
  localparam int unsigned TAW      = $clog2(SAMPLES * 2)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tbl_we_i,
  input  logic [TAW-1:0] tbl_addr_i,
  input  logic [7:0]     tbl_data_i,
  output logic           dac_cs_no,
  output logic           dac_we_no,
  output logic [1:0]     dac_addr_o,
  output logic [7:0]     dac_data_o,
  output logic           dac_ldac_no,
  output logic           overrun_o
);
  localparam int unsigned HI_KEEP = 4;  // 12-bit word: upper byte carries 4 bits

  logic           tick;
  logic [TAW-2:0] ridx;
  logic [HI_KEEP-1:0] rhi;
  logic [7:0]     rlo;

  dac_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dac_wave_table #(.SAMPLES(SAMPLES), .HI_KEEP(HI_KEEP)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .waddr_i(tbl_addr_i),
    .wdata_i(tbl_data_i),
    .ridx_i (ridx),
    .rhi_o  (rhi),
    .rlo_o  (rlo)
  );

  dac_bus_seq #(
    .SAMPLES  (SAMPLES),
    .PHASE_CYC(PHASE_CYC),
    .HI_KEEP  (HI_KEEP),
    .CFG_WORD (CFG_WORD)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .rhi_i    (rhi),
    .rlo_i    (rlo),
    .ridx_o   (ridx),
    .cs_no    (dac_cs_no),
    .we_no    (dac_we_no),
    .addr_o   (dac_addr_o),
    .data_o   (dac_data_o),
    .ldac_no  (dac_ldac_no),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/dac_wave_seq_chk.sv
module dac_wave_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dac_cs_no,
  input logic       dac_we_no,
  input logic [1:0] dac_addr_o,
  input logic [7:0] dac_data_o,
  input logic       dac_ldac_no,
  input logic       overrun_o
);
  a_r6_strobe_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_we_no |-> !dac_cs_no);

  a_r6_bus_stable_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_we_no && !$past(dac_we_no)) |-> ($stable(dac_addr_o) && $stable(dac_data_o)));

  a_r6_bus_stable_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_we_no) |-> ($stable(dac_addr_o) && $stable(dac_data_o)));

  a_r7_load_with_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_ldac_no |-> (dac_cs_no && dac_we_no));

  a_r4_upper_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no && dac_addr_o == 2'd1) |-> (dac_data_o[7:4] == 4'h0));

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind dac_wave_seq dac_wave_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dac_cs_no  (dac_cs_no),
  .dac_we_no  (dac_we_no),
  .dac_addr_o (dac_addr_o),
  .dac_data_o (dac_data_o),
  .dac_ldac_no(dac_ldac_no),
  .overrun_o  (overrun_o)
);

// File: tb/tb_dac_wave_seq.sv
// Bus-side model of the DAC: captures writes on rising strobe, logs each load.
module dac_bus_mon (
  input logic       clk_i,
  input logic       cs_ni,
  input logic       we_ni,
  input logic [1:0] addr_i,
  input logic [7:0] data_i,
  input logic       ldac_ni
);
  int cyc = 0, wr_cnt = 0, ld_cnt = 0, cfg_cnt = 0, since = 0, last_fall = 0, ld_width = 0;
  logic [1:0] first_addr = '0, a1 = '0, a2 = '0;
  logic [7:0] first_data = '0, hi_r = '0, lo_r = '0;
  logic [11:0] ld_val [64];
  int          ld_gap [64];
  int          ld_since [64];
  bit          ld_pair [64];

  always @(posedge clk_i) cyc++;

  always @(posedge we_ni) if (cs_ni === 1'b0) begin
    if (wr_cnt == 0) begin first_addr = addr_i; first_data = data_i; end
    wr_cnt++;
    since++;
    a2 = a1;
    a1 = addr_i;
    if (addr_i == 2'd1) hi_r = data_i;
    else if (addr_i == 2'd0) lo_r = data_i;
    else if (addr_i == 2'd3 && data_i == 8'h11) cfg_cnt++;
  end

  always @(negedge ldac_ni) begin
    if (ld_cnt < 64) begin
      ld_val[ld_cnt]   = {hi_r[3:0], lo_r};
      ld_gap[ld_cnt]   = cyc - last_fall;
      ld_pair[ld_cnt]  = (a2 == 2'd1) && (a1 == 2'd0);
      ld_since[ld_cnt] = since;
    end
    last_fall = cyc;
    since = 0;
    ld_cnt++;
  end

  always @(posedge ldac_ni) ld_width = cyc - last_fall;
endmodule

module tb_dac_wave_seq;
  localparam int unsigned DIV_MAIN = 50;
  localparam int unsigned DIV_OVR  = 12;
  localparam int unsigned PH       = 2;
  localparam int unsigned NS       = 32;
  localparam int unsigned NLOAD    = 34;
  localparam logic [15:0] PAT [8] = '{16'h0000, 16'h0FFF, 16'hF800, 16'h0001,
                                      16'hA5A5, 16'h07FE, 16'h5C3A, 16'hFFFF};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic       cs_n, we_n, ldac_n, ovr;
  logic [1:0] addr;
  logic [7:0] data;
  logic       cs_n2, we_n2, ldac_n2, ovr2;
  logic [1:0] addr2;
  logic [7:0] data2;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  dac_wave_seq #(.SAMPLES(NS), .TICK_DIV(DIV_MAIN), .PHASE_CYC(PH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data), .dac_cs_no(cs_n), .dac_we_no(we_n), .dac_addr_o(addr),
    .dac_data_o(data), .dac_ldac_no(ldac_n), .overrun_o(ovr));

  dac_wave_seq #(.SAMPLES(NS), .TICK_DIV(DIV_OVR), .PHASE_CYC(PH)) dut_ovr (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data), .dac_cs_no(cs_n2), .dac_we_no(we_n2), .dac_addr_o(addr2),
    .dac_data_o(data2), .dac_ldac_no(ldac_n2), .overrun_o(ovr2));

  dac_bus_mon u_mon (.clk_i(clk), .cs_ni(cs_n), .we_ni(we_n), .addr_i(addr),
                     .data_i(data), .ldac_ni(ldac_n));
  dac_bus_mon u_mon_ovr (.clk_i(clk), .cs_ni(cs_n2), .we_ni(we_n2), .addr_i(addr2),
                         .data_i(data2), .ldac_ni(ldac_n2));

  function automatic logic [15:0] wave(int i);
    if (i < 8) return PAT[i];
    return 16'((i * 311) ^ 16'hA000 ^ (i << 13));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({cs_n, we_n, ldac_n, cs_n2, we_n2, ldac_n2} == 6'h3F, "R1", "strobes high in reset",
        {cs_n, we_n, ldac_n}, 3'b111);
    chk(!ovr && !ovr2, "R1", "overrun low in reset", ovr, 0);
    rst_n = 1'b1;
    // R10: fill table, even byte upper, odd byte lower
    for (int b = 0; b < 2 * NS; b++) begin
      tbl_we   = 1'b1;
      tbl_addr = 6'(b);
      tbl_data = b[0] ? wave(b >> 1)[7:0] : wave(b >> 1)[15:8];
      @(negedge clk);
    end
    tbl_we = 1'b0;

    wait (u_mon.ld_cnt >= NLOAD);
    @(negedge clk);

    // R2: configuration write first
    chk(u_mon.first_addr == 2'd3, "R2", "first write address", u_mon.first_addr, 3);
    chk(u_mon.first_data == 8'h11, "R2", "first write data", u_mon.first_data, 8'h11);
    chk(u_mon.ld_since[0] == 3, "R2", "writes before first load", u_mon.ld_since[0], 3);

    // main vector walk: R3 R4 R5 R8 R10
    for (int k = 0; k < NLOAD; k++) begin
      logic [11:0] e;
      e = wave(k % NS)[11:0];
      chk(u_mon.ld_val[k] == e, "R4/R5/R10", $sformatf("load %0d word", k), u_mon.ld_val[k], e);
      chk(u_mon.ld_pair[k], "R3", $sformatf("load %0d hi-then-lo", k), u_mon.ld_pair[k], 1);
      if (k > 0) begin
        chk(u_mon.ld_since[k] == 2, "R3", $sformatf("load %0d write count", k), u_mon.ld_since[k], 2);
        chk(u_mon.ld_gap[k] == DIV_MAIN, "R8", $sformatf("load %0d spacing", k), u_mon.ld_gap[k], DIV_MAIN);
      end
    end
    chk(u_mon.ld_width == PH, "R7", "load pulse width", u_mon.ld_width, PH);
    chk(ovr == 1'b0, "R9", "no overrun at wide divider", ovr, 0);

    // R9: overrun instance drops every other tick but keeps sample order
    chk(ovr2 == 1'b1, "R9", "overrun flagged", ovr2, 1);
    for (int k = 0; k < NLOAD; k++) begin
      logic [11:0] e;
      e = wave(k % NS)[11:0];
      chk(u_mon_ovr.ld_val[k] == e, "R9", $sformatf("ovr load %0d word", k), u_mon_ovr.ld_val[k], e);
      if (k > 0)
        chk(u_mon_ovr.ld_gap[k] == 2 * DIV_OVR, "R9", $sformatf("ovr load %0d spacing", k),
            u_mon_ovr.ld_gap[k], 2 * DIV_OVR);
    end

    // R1/R2/R10: reset mid-run clears table and flag, config rewritten
    rst_n = 1'b0;
    @(negedge clk);
    chk({cs_n, we_n, ldac_n} == 3'b111, "R1", "strobes high after mid-run reset",
        {cs_n, we_n, ldac_n}, 3'b111);
    chk(ovr2 == 1'b0, "R1", "overrun cleared by reset", ovr2, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int n;
      n = u_mon.ld_cnt;
      wait (u_mon.ld_cnt >= n + 1);
      @(negedge clk);
      chk(u_mon.ld_val[n] == 12'h000, "R1", "table cleared by reset", u_mon.ld_val[n], 0);
      chk(u_mon.ld_since[n] == 3, "R2", "config rewrite before load", u_mon.ld_since[n], 3);
    end
    chk(u_mon.cfg_cnt == 2 && u_mon_ovr.cfg_cnt == 2, "R2", "config write count",
        u_mon.cfg_cnt, 2);

    summary();
    $finish;
  end
endmodule